// File: doc/BRIEF.md
# Data Toggle Sequence Tracker

This block holds one sequence bit per endpoint, so that the two ends of a long transfer agree on which data packet comes next. It serves either side of a transaction. In the sending role it names the data packet type to put on the wire and moves its bit forward only when a clean acknowledge comes back. In the receiving role it compares the type of each incoming data packet with its bit. It accepts the payload and moves forward only on a good packet whose type matches. Isochronous traffic is excluded from sequencing.

The surrounding controller presents one event per cycle for a selected endpoint: a received data packet (receiving role) or the end of a handshake window (sending role). It can also present a clear request. The block answers with the data PID to send, available combinationally for the selected endpoint, and with registered accept and acknowledge-request pulses one cycle after a received packet. CRC checking, token decoding and bit-level signalling live elsewhere. The controller reports packet integrity through a single good flag.

Top module: `dtog_tracker`

## Requirements
- R1: While and after reset every endpoint's bit is 0, `tx_pid` reads 0xC3 and `data_accept` and `ack_req` are low.
- R2: For a sequenced transfer kind, `tx_pid` is 0xC3 (DATA0) when the selected endpoint's bit is 0 and 0x4B (DATA1) when it is 1.
- R3: In the sending role, a cycle with `hs_done` and `hs_ack_ok` both high inverts the selected endpoint's bit at that clock edge.
- R4: In the sending role, `hs_done` with `hs_ack_ok` low, or `hs_ack_ok` without `hs_done`, leaves the bit unchanged, so a retry uses the same PID.
- R5: In the receiving role, a `rx_valid` cycle with `rx_good` high and `rx_pid` equal to the endpoint's expected PID inverts the bit. In the next cycle it raises both `data_accept` and `ack_req` for one cycle.
- R6: In the receiving role, a good data packet of the wrong type keeps the bit and raises `ack_req` without `data_accept` in the next cycle.
- R7: In the receiving role, a packet with `rx_good` low raises neither output and keeps the bit.
- R8: Transfer kind encoding is 00 control, 01 isochronous, 10 bulk, 11 interrupt. For isochronous (01) the bit never changes and `tx_pid` is 0xC3. A good DATA0 or DATA1 is accepted without `ack_req`.
- R9: `clr_req` forces the selected endpoint's bit to 0 at the clock edge, overriding an advance in the same cycle.
- R10: `rx_valid` has no effect while `is_sender` is high, and `hs_done` has no effect while it is low.
- R11: A received PID other than 0xC3 or 0x4B raises neither output and keeps the bit.
- R12: An event changes only the bit of the endpoint selected by `ep_idx`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ep_idx | input | EP_W | Endpoint selected this cycle |
| xfer_kind | input | 2 | Transfer kind: 00 control, 01 isochronous, 10 bulk, 11 interrupt |
| is_sender | input | 1 | 1 = this side transmits the data packet |
| rx_valid | input | 1 | A data packet finished arriving this cycle |
| rx_pid | input | 8 | PID byte of the arrived packet |
| rx_good | input | 1 | The arrived packet was free of errors |
| hs_done | input | 1 | Handshake window closed this cycle |
| hs_ack_ok | input | 1 | An error-free ACK was seen in that window |
| clr_req | input | 1 | Force the selected endpoint's bit to 0 |
| tx_pid | output | 8 | Data PID to transmit for the selected endpoint |
| data_accept | output | 1 | Payload of the previous cycle's packet is to be kept |
| ack_req | output | 1 | Send an ACK for the previous cycle's packet |

## Verification
The assertions assume that `ep_idx` stays below the endpoint count and that the controller presents at most one event per cycle for the one selected endpoint. Under that assumption, at most one bit changes per edge and a cleared endpoint reads 0 afterwards. The stimulus only ever picks valid endpoint numbers, and it holds every input for a whole cycle, changing inputs on the falling edge. In the mixed phase, the role, kind, PID and flag combinations are drawn freely, including illegal PIDs and role-mismatched events. This is so that the gating rules are exercised.

// File: rtl/dtog_pkg.sv
package dtog_pkg;

    typedef enum logic [1:0] {
        XF_CTRL = 2'b00,
        XF_ISO  = 2'b01,
        XF_BULK = 2'b10,
        XF_INTR = 2'b11
    } xfer_e;

    localparam logic [7:0] PID_SEQ0 = 8'hC3;
    localparam logic [7:0] PID_SEQ1 = 8'h4B;

    typedef struct packed {
        logic is_data;
        logic seq;
    } pid_info_t;

    typedef struct packed {
        logic flip;
        logic accept;
        logic ack;
    } rx_verdict_t;

    function automatic pid_info_t decode_pid(input logic [7:0] p);
        pid_info_t r;
        r.is_data = (p == PID_SEQ0) || (p == PID_SEQ1);
        r.seq     = (p == PID_SEQ1);
        return r;
    endfunction

    function automatic logic [7:0] encode_pid(input logic seq);
        return seq ? PID_SEQ1 : PID_SEQ0;
    endfunction

    function automatic logic is_sequenced(input xfer_e k);
        return k != XF_ISO;
    endfunction

endpackage

// File: rtl/dtog_rx_check.sv
module dtog_rx_check
    import dtog_pkg::*;
(
    input  logic        active,
    input  logic [7:0]  pid,
    input  logic        good,
    input  logic        tracked,
    input  logic        cur_seq,
    output rx_verdict_t verdict
);
    pid_info_t info;

    always_comb begin
        info    = decode_pid(pid);
        verdict = '0;
        if (active && good && info.is_data) begin
            if (tracked) begin
                verdict.ack    = 1'b1;
                verdict.accept = (info.seq == cur_seq);
                verdict.flip   = (info.seq == cur_seq);
            end else begin
                verdict.accept = 1'b1;
            end
        end
    end
endmodule

// File: rtl/dtog_tx_advance.sv
module dtog_tx_advance
    import dtog_pkg::*;
(
    input  logic       active,
    input  logic       ack_ok,
    input  logic       tracked,
    input  logic       cur_seq,
    output logic       flip,
    output logic [7:0] pid_out
);
    always_comb begin
        flip    = active && ack_ok && tracked;
        pid_out = tracked ? encode_pid(cur_seq) : PID_SEQ0;
    end
endmodule

// File: rtl/dtog_state.sv
module dtog_state #(
    parameter int NUM_EP = 4,
    parameter int EP_W   = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [EP_W-1:0]   sel,
    input  logic              flip,
    input  logic              clr,
    output logic [NUM_EP-1:0] seq_vec,
    output logic              cur
);
    for (genvar i = 0; i < NUM_EP; i++) begin : g_ep
        logic hit;
        assign hit = (sel == EP_W'(i));
        always_ff @(posedge clk) begin
            if (rst)
                seq_vec[i] <= 1'b0;
            else if (clr && hit)
                seq_vec[i] <= 1'b0;
            else if (flip && hit)
                seq_vec[i] <= ~seq_vec[i];
        end
    end

    always_comb begin
        cur = 1'b0;
        for (int j = 0; j < NUM_EP; j++)
            if (sel == EP_W'(j))
                cur = seq_vec[j];
    end
endmodule

// File: rtl/dtog_tracker.sv
module dtog_tracker
    import dtog_pkg::*;
#(
    parameter int NUM_EP = 4,
    localparam int EP_W  = (NUM_EP > 1) ? $clog2(NUM_EP) : 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [EP_W-1:0] ep_idx,
    input  logic [1:0]      xfer_kind,
    input  logic            is_sender,
    input  logic            rx_valid,
    input  logic [7:0]      rx_pid,
    input  logic            rx_good,
    input  logic            hs_done,
    input  logic            hs_ack_ok,
    input  logic            clr_req,
    output logic [7:0]      tx_pid,
    output logic            data_accept,
    output logic            ack_req
);
    logic              tracked;
    logic              cur_seq;
    logic [NUM_EP-1:0] seq_vec;
    logic              tx_flip;
    rx_verdict_t       rx_v;
    logic              accept_q;
    logic              ack_q;

    assign tracked = is_sequenced(xfer_e'(xfer_kind));

    dtog_rx_check u_rx (
        .active  (rx_valid && !is_sender),
        .pid     (rx_pid),
        .good    (rx_good),
        .tracked (tracked),
        .cur_seq (cur_seq),
        .verdict (rx_v)
    );

    dtog_tx_advance u_tx (
        .active  (hs_done && is_sender),
        .ack_ok  (hs_ack_ok),
        .tracked (tracked),
        .cur_seq (cur_seq),
        .flip    (tx_flip),
        .pid_out (tx_pid)
    );

    dtog_state #(.NUM_EP(NUM_EP), .EP_W(EP_W)) u_st (
        .clk     (clk),
        .rst     (rst),
        .sel     (ep_idx),
        .flip    (tx_flip || rx_v.flip),
        .clr     (clr_req),
        .seq_vec (seq_vec),
        .cur     (cur_seq)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            accept_q <= 1'b0;
            ack_q    <= 1'b0;
        end else begin
            accept_q <= rx_v.accept;
            ack_q    <= rx_v.ack;
        end
    end

    assign data_accept = accept_q;
    assign ack_req     = ack_q;
endmodule

// File: rtl/dtog_checker.sv
module dtog_checker #(
    parameter int NUM_EP = 4,
    parameter int EP_W   = 2
) (
    input logic              clk,
    input logic              rst,
    input logic [EP_W-1:0]   ep_idx,
    input logic [1:0]        xfer_kind,
    input logic              is_sender,
    input logic              rx_valid,
    input logic              rx_good,
    input logic              clr_req,
    input logic [7:0]        tx_pid,
    input logic              data_accept,
    input logic              ack_req,
    input logic [NUM_EP-1:0] seq_vec
);
    assert_pid_legal_R2: assert property (@(posedge clk) disable iff (rst)
        (tx_pid == 8'hC3) || (tx_pid == 8'h4B));

    assert_iso_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (xfer_kind == 2'b01 && !clr_req) |=> (seq_vec == $past(seq_vec)));

    assert_ack_cause_R7: assert property (@(posedge clk) disable iff (rst)
        ack_req |-> $past(rx_valid && rx_good && !is_sender));

    assert_accept_acked_R5: assert property (@(posedge clk) disable iff (rst)
        (data_accept && $past(xfer_kind) != 2'b01) |-> ack_req);

    assert_clear_R9: assert property (@(posedge clk) disable iff (rst)
        clr_req |=> (seq_vec[$past(ep_idx)] == 1'b0));

    assert_role_gate_R10: assert property (@(posedge clk) disable iff (rst)
        is_sender |=> (!ack_req && !data_accept));

    assert_single_change_R12: assert property (@(posedge clk) disable iff (rst)
        $countones(seq_vec ^ $past(seq_vec)) <= 1);
endmodule

bind dtog_tracker dtog_checker #(.NUM_EP(NUM_EP), .EP_W(EP_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .ep_idx      (ep_idx),
    .xfer_kind   (xfer_kind),
    .is_sender   (is_sender),
    .rx_valid    (rx_valid),
    .rx_good     (rx_good),
    .clr_req     (clr_req),
    .tx_pid      (tx_pid),
    .data_accept (data_accept),
    .ack_req     (ack_req),
    .seq_vec     (seq_vec)
);

// File: tb/sim_dtog_tracker.sv
module sim_dtog_tracker;
    localparam int NEP = 4;
    localparam logic [7:0] D0 = 8'hC3;
    localparam logic [7:0] D1 = 8'h4B;

    logic       clk = 1'b0;
    logic       rst;
    logic [1:0] ep_idx;
    logic [1:0] xfer_kind;
    logic       is_sender, rx_valid, rx_good, hs_done, hs_ack_ok, clr_req;
    logic [7:0] rx_pid;
    logic [7:0] tx_pid;
    logic       data_accept, ack_req;

    int errors = 0;
    int checks = 0;
    bit model_seq [NEP];
    bit finished = 0;

    always #10 clk = ~clk;

    dtog_tracker #(.NUM_EP(NEP)) u0 (
        .clk(clk), .rst(rst), .ep_idx(ep_idx), .xfer_kind(xfer_kind),
        .is_sender(is_sender), .rx_valid(rx_valid), .rx_pid(rx_pid),
        .rx_good(rx_good), .hs_done(hs_done), .hs_ack_ok(hs_ack_ok),
        .clr_req(clr_req), .tx_pid(tx_pid), .data_accept(data_accept),
        .ack_req(ack_req)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step(input string req, input int ep, input int kind, input bit snd,
                        input bit rxv, input logic [7:0] pid, input bit good,
                        input bit hsd, input bit hok, input bit clr);
        bit acc, ack, flip, is_data;
        logic [7:0] exp_pid;
        ep_idx = 2'(ep); xfer_kind = 2'(kind); is_sender = snd;
        rx_valid = rxv; rx_pid = pid; rx_good = good;
        hs_done = hsd; hs_ack_ok = hok; clr_req = clr;
        #1;
        exp_pid = (kind == 1) ? D0 : (model_seq[ep] ? D1 : D0);
        chk({req, " tx_pid"}, tx_pid, exp_pid);
        acc = 0; ack = 0; flip = 0;
        is_data = (pid == D0) || (pid == D1);
        if (!snd && rxv && good && is_data) begin
            if (kind == 1) acc = 1;
            else begin
                ack = 1;
                if ((pid == D1) == model_seq[ep]) begin acc = 1; flip = 1; end
            end
        end
        if (snd && hsd && hok && kind != 1) flip = 1;
        @(posedge clk);
        if (clr) model_seq[ep] = 0;
        else if (flip) model_seq[ep] = !model_seq[ep];
        @(negedge clk);
        chk({req, " data_accept"}, {7'd0, data_accept}, {7'd0, acc});
        chk({req, " ack_req"}, {7'd0, ack_req}, {7'd0, ack});
    endtask

    task automatic peek_all(input string req);
        for (int e = 0; e < NEP; e++)
            step(req, e, 2, 1, 0, 8'h00, 0, 0, 0, 0);
    endtask

    initial begin
        #2000000;
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        for (int e = 0; e < NEP; e++) model_seq[e] = 0;
        rst = 1; ep_idx = 0; xfer_kind = 2; is_sender = 0; rx_valid = 0;
        rx_pid = 0; rx_good = 0; hs_done = 0; hs_ack_ok = 0; clr_req = 0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 tx_pid", tx_pid, D0);
        chk("R1 data_accept", {7'd0, data_accept}, 8'd0);
        chk("R1 ack_req", {7'd0, ack_req}, 8'd0);
        rst = 0;
        peek_all("R1");

        // R2 / R3: sender, bulk, clean ACKs on ep0
        step("R3", 0, 2, 1, 0, 8'h00, 0, 1, 1, 0);
        step("R2", 0, 2, 1, 0, 8'h00, 0, 0, 0, 0);
        step("R3", 0, 2, 1, 0, 8'h00, 0, 1, 1, 0);
        step("R2", 0, 2, 1, 0, 8'h00, 0, 0, 0, 0);
        step("R3", 0, 0, 1, 0, 8'h00, 0, 1, 1, 0);
        // R4: failed or missing handshake keeps PID
        step("R4", 0, 0, 1, 0, 8'h00, 0, 1, 0, 0);
        step("R4", 0, 0, 1, 0, 8'h00, 0, 0, 1, 0);
        step("R4", 0, 0, 1, 0, 8'h00, 0, 0, 0, 0);

        // R5: receiver, interrupt, ep1
        step("R5", 1, 3, 0, 1, D0, 1, 0, 0, 0);
        step("R5", 1, 3, 0, 1, D1, 1, 0, 0, 0);
        // R6: wrong type
        step("R6", 1, 3, 0, 1, D1, 1, 0, 0, 0);
        step("R6", 1, 3, 0, 0, 8'h00, 0, 0, 0, 0);
        // R7: corrupted
        step("R7", 1, 3, 0, 1, D0, 0, 0, 0, 0);
        step("R7", 1, 3, 0, 1, D1, 0, 0, 0, 0);
        step("R5", 1, 3, 0, 1, D0, 1, 0, 0, 0);
        // R11: not a data PID
        step("R11", 1, 3, 0, 1, 8'h69, 1, 0, 0, 0);
        step("R11", 1, 3, 0, 1, 8'hD2, 1, 0, 0, 0);
        peek_all("R12");

        // R8: isochronous
        step("R8", 2, 1, 1, 0, 8'h00, 0, 1, 1, 0);
        step("R8", 2, 1, 0, 1, D1, 1, 0, 0, 0);
        step("R8", 2, 1, 0, 1, D0, 1, 0, 0, 0);
        step("R8", 2, 2, 1, 0, 8'h00, 0, 0, 0, 0);

        // R10: role gating
        step("R10", 2, 2, 1, 1, D0, 1, 0, 0, 0);
        step("R10", 2, 2, 0, 0, 8'h00, 0, 1, 1, 0);
        step("R10", 2, 2, 1, 0, 8'h00, 0, 0, 0, 0);

        // R9: clear, including clear over a same-cycle advance
        step("R9", 3, 0, 1, 0, 8'h00, 0, 1, 1, 0);
        step("R9", 3, 0, 1, 0, 8'h00, 0, 0, 0, 1);
        step("R9", 3, 0, 1, 0, 8'h00, 0, 1, 1, 1);
        step("R9", 3, 0, 0, 1, D0, 1, 0, 0, 1);
        peek_all("R9");

        // R12: mixed traffic across endpoints
        for (int n = 0; n < 400; n++) begin
            int e, k;
            bit s, rv, g, hd, ho, cl;
            logic [7:0] p;
            e = int'($urandom_range(NEP - 1));
            k = int'($urandom_range(3));
            s = 1'($urandom); rv = 1'($urandom); g = ($urandom_range(3) != 0);
            hd = 1'($urandom); ho = 1'($urandom); cl = ($urandom_range(15) == 0);
            case ($urandom_range(4))
                0, 1:    p = D0;
                2, 3:    p = D1;
                default: p = 8'(($urandom_range(255)));
            endcase
            step("R12", e, k, s, rv, p, g, hd, ho, cl);
        end
        peek_all("R12");

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule